// File: doc/BRIEF.md
# Supervisory Reset Sequencer

This block turns already-synchronised supply comparator flags and a raw push-button input into a clean system reset. The reset is held low while the main supply is below its threshold or while the debounced manual input is pressed. It is also held low at power-up. Once every cause has gone away, the reset stays low for a hold time before it releases. The hold time is a number of 1 ms ticks chosen by a select input.

Two status flags bypass the hold timer and follow their comparators directly. The low-line flag follows the main supply flag. The secondary-fail flag follows the secondary supply flag and never affects the reset. A busy output is high for exactly the cycles in which the reset is asserted, so that serial-bus logic elsewhere on the chip can ignore traffic during that time.

All outputs are registered. The raw manual input passes through a two-stage synchroniser and then a tick-based debouncer before it can act as a reset cause.

Top module: `supv_reset_seq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `sys_rst_n` is 0 and `busy` is 1.
- R2: At power-up, with the main supply good and the manual input released, `sys_rst_n` rises when the hold time has elapsed, counted in ticks seen after `rst` falls. The default hold time is 150 ticks.
- R3: The main supply flag going low drives `sys_rst_n` to 0 two clock cycles later. `sys_rst_n` stays 0 for as long as the flag stays low.
- R4: After the last reset cause clears, `sys_rst_n` releases once a number of ticks has been counted, starting from the first tick seen after the cause cleared. The count is 150 ticks when `long_dly` is 0 and 800 ticks when `long_dly` is 1.
- R5: `lowline_n` equals the main supply flag delayed by one clock cycle. The hold timer never delays it.
- R6: `aux_fail_n` equals the secondary supply flag delayed by one clock cycle. The secondary flag has no effect on `sys_rst_n`.
- R7: The manual input is accepted at a new level only after its synchronised value has differed from the accepted level on 16 consecutive ticks. Returning to the accepted level for any single cycle clears that count, so a press shorter than 16 ticks never causes a reset.
- R8: A debounced manual press (`man_rst_raw_n` = 0) holds `sys_rst_n` at 0. The hold time begins once the debounced input returns to 1.
- R9: A new reset cause arriving during the hold time restarts the count from zero. A full hold time is then needed after that cause clears.
- R10: `busy` is the inverse of `sys_rst_n` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| vmain_ok | input | 1 | Main supply is above its trip threshold |
| vaux_ok | input | 1 | Secondary supply is above its trip threshold |
| man_rst_raw_n | input | 1 | Raw asynchronous manual reset, active low |
| long_dly | input | 1 | Hold-time select: 0 gives the short hold, 1 gives the long hold |
| sys_rst_n | output | 1 | System reset, active low |
| lowline_n | output | 1 | Main supply low flag, active low, no hold time |
| aux_fail_n | output | 1 | Secondary supply fail flag, active low, no hold time |
| busy | output | 1 | High while the system reset is asserted |

## Verification
The key collision is between a fresh reset cause and a hold count that is already under way. A short supply dip placed about 100 ticks into a hold must reset the count to zero rather than let it expire. That release is then judged by counting ticks from the second recovery. A second coincidence occurs when a supply dip lowers `lowline_n` and `sys_rst_n` one cycle apart. The two recover at very different times: the flag recovers at once, while the reset waits out the hold. A behavioural model in the bench predicts every output on every cycle, so any wrong cycle at either edge shows up.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic {
    HOLD_OFF = 1'b0,
    HOLD_ON  = 1'b1
  } hold_e;

  function automatic int unsigned sel_hold_ticks(input logic long_sel,
                                                 input int unsigned short_t,
                                                 input int unsigned long_t);
    return long_sel ? long_t : short_t;
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= RST_VAL;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/supv_debounce.sv
module supv_debounce #(
  parameter int STABLE_TICKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic level
);
  localparam int CW = (STABLE_TICKS > 1) ? $clog2(STABLE_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STABLE_TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b1;
      cnt   <= '0;
    end else if (din == level) begin
      cnt <= '0;
    end else if (tick) begin
      if (cnt == LAST) begin
        level <= din;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/supv_hold_timer.sv
module supv_hold_timer
  import supv_pkg::*;
#(
  parameter int SHORT_TICKS = 150,
  parameter int LONG_TICKS  = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cause,
  input  logic long_sel,
  output logic hold
);
  localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  hold_e         st;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;

  always_comb last = CW'(sel_hold_ticks(long_sel, SHORT_TICKS, LONG_TICKS) - 1);

  always_ff @(posedge clk) begin
    if (rst || cause) begin
      st  <= HOLD_ON;
      cnt <= '0;
    end else if (st == HOLD_ON && tick) begin
      if (cnt >= last) begin
        st  <= HOLD_OFF;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign hold = (st == HOLD_ON);
endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq #(
  parameter int SHORT_TICKS = 150,
  parameter int LONG_TICKS  = 800,
  parameter int DEB_TICKS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_1ms,
  input  logic vmain_ok,
  input  logic vaux_ok,
  input  logic man_rst_raw_n,
  input  logic long_dly,
  output logic sys_rst_n,
  output logic lowline_n,
  output logic aux_fail_n,
  output logic busy
);
  logic man_sync_n;
  logic man_deb_n;
  logic hold;
  logic cause;

  supv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(man_rst_raw_n), .q(man_sync_n)
  );

  supv_debounce #(.STABLE_TICKS(DEB_TICKS)) u_deb (
    .clk(clk), .rst(rst), .tick(tick_1ms), .din(man_sync_n), .level(man_deb_n)
  );

  assign cause = ~vmain_ok | ~man_deb_n;

  supv_hold_timer #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_timer (
    .clk(clk), .rst(rst), .tick(tick_1ms), .cause(cause),
    .long_sel(long_dly), .hold(hold)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_rst_n <= 1'b0;
      busy      <= 1'b1;
    end else begin
      sys_rst_n <= ~hold;
      busy      <= hold;
    end
  end

  // status flags follow their comparators even during reset
  always_ff @(posedge clk) begin
    lowline_n  <= vmain_ok;
    aux_fail_n <= vaux_ok;
  end
endmodule

// File: rtl/supv_reset_seq_chk.sv
module supv_reset_seq_chk #(
  parameter int DEB_TICKS = 16
) (
  input logic clk,
  input logic rst,
  input logic tick_1ms,
  input logic vmain_ok,
  input logic vaux_ok,
  input logic man_rst_raw_n,
  input logic sys_rst_n,
  input logic lowline_n,
  input logic aux_fail_n
);
  localparam int unsigned LOW_LIM = DEB_TICKS + 4;
  int unsigned low_ticks;

  always_ff @(posedge clk) begin
    if (rst || man_rst_raw_n) low_ticks <= 0;
    else if (tick_1ms && low_ticks < LOW_LIM) low_ticks <= low_ticks + 1;
  end

  AST_SUPPLY_LOSS: assert property (@(posedge clk) disable iff (rst)
    !vmain_ok |-> ##2 !sys_rst_n); // R3

  AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_n) |-> $past(vmain_ok, 2)); // R4

  AST_LOWLINE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    lowline_n == $past(vmain_ok)); // R5

  AST_AUX_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    aux_fail_n == $past(vaux_ok)); // R6

  AST_MANUAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (low_ticks >= LOW_LIM) |-> !sys_rst_n); // R8
endmodule

bind supv_reset_seq supv_reset_seq_chk #(.DEB_TICKS(DEB_TICKS)) u_chk (
  .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .vmain_ok(vmain_ok),
  .vaux_ok(vaux_ok), .man_rst_raw_n(man_rst_raw_n), .sys_rst_n(sys_rst_n),
  .lowline_n(lowline_n), .aux_fail_n(aux_fail_n)
);

// File: tb/supv_reset_seq_test.sv
`timescale 1ns/1ps
module supv_reset_seq_test;
  localparam int SHORT = 150;
  localparam int LONG  = 800;
  localparam int DEB   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1ms = 1'b0;
  logic vmain_ok = 1'b1;
  logic vaux_ok = 1'b1;
  logic man_rst_raw_n = 1'b1;
  logic long_dly = 1'b0;
  logic sys_rst_n, lowline_n, aux_fail_n, busy;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;
  int cyc = 0;
  int tk_total = 0;

  // behavioural reference state
  int m_s1 = 1, m_s2 = 1, m_deb = 1, m_dcnt = 0;
  int m_hold = 1, m_hcnt = 0, m_rstn = 0, m_busy = 1, m_ll = 1, m_af = 1;

  always #2 clk = ~clk;

  supv_reset_seq uut (
    .clk(clk), .rst(rst), .tick_1ms(tick_1ms), .vmain_ok(vmain_ok),
    .vaux_ok(vaux_ok), .man_rst_raw_n(man_rst_raw_n), .long_dly(long_dly),
    .sys_rst_n(sys_rst_n), .lowline_n(lowline_n), .aux_fail_n(aux_fail_n),
    .busy(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // tick on every other cycle
  always @(negedge clk) begin
    cyc++;
    tick_1ms <= (cyc % 2 == 0);
  end

  always @(posedge clk) begin
    int cause, limit;
    if (tick_1ms) tk_total++;
    if (rst) begin
      m_hold = 1; m_hcnt = 0; m_deb = 1; m_dcnt = 0;
      m_s1 = 1; m_s2 = 1; m_rstn = 0; m_busy = 1;
    end else begin
      m_rstn = m_hold ? 0 : 1;
      m_busy = m_hold;
      cause = (!vmain_ok || m_deb == 0) ? 1 : 0;
      limit = long_dly ? LONG : SHORT;
      if (cause) begin
        m_hold = 1; m_hcnt = 0;
      end else if (m_hold && tick_1ms) begin
        if (m_hcnt >= limit - 1) begin m_hold = 0; m_hcnt = 0; end
        else m_hcnt++;
      end
      if (m_s2 == m_deb) m_dcnt = 0;
      else if (tick_1ms) begin
        if (m_dcnt == DEB - 1) begin m_deb = m_s2; m_dcnt = 0; end
        else m_dcnt++;
      end
      m_s2 = m_s1;
      m_s1 = man_rst_raw_n;
    end
    m_ll = vmain_ok;
    m_af = vaux_ok;
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R3 sys_rst_n vs model", sys_rst_n, m_rstn);
      chk("R5 lowline_n vs model", lowline_n, m_ll);
      chk("R6 aux_fail_n vs model", aux_fail_n, m_af);
      chk("R10 busy vs model", busy, m_busy);
      chk("R10 busy inverse of reset", busy, !sys_rst_n);
    end
  end

  task automatic wait_release(input int mark, output int ticks);
    int n = 0;
    while (sys_rst_n !== 1'b1 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    ticks = tk_total - mark;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int mark, mark0, t, minv;
    repeat (2) @(negedge clk);
    cmp_on = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset asserted in rst", sys_rst_n, 0);
    chk("R1 busy in rst", busy, 1);
    rst = 1'b0;
    mark = tk_total;
    @(negedge clk);
    chk("R1 reset still low after rst", sys_rst_n, 0);
    chk("R5 lowline high at power-up", lowline_n, 1);
    wait_release(mark, t);
    chk("R2 power-up hold ticks", t, SHORT);

    // supply dip, short hold
    vmain_ok = 1'b0;
    @(negedge clk);
    chk("R5 lowline low one cycle after dip", lowline_n, 0);
    @(negedge clk);
    chk("R3 reset low two cycles after dip", sys_rst_n, 0);
    repeat (20) @(negedge clk);
    chk("R3 reset held during dip", sys_rst_n, 0);
    vmain_ok = 1'b1;
    mark = tk_total;
    @(negedge clk);
    chk("R5 lowline recovers with no hold", lowline_n, 1);
    chk("R4 reset still held after recovery", sys_rst_n, 0);
    wait_release(mark, t);
    chk("R4 short hold ticks", t, SHORT);

    // secondary supply
    vaux_ok = 1'b0;
    @(negedge clk);
    chk("R6 aux fail follows", aux_fail_n, 0);
    repeat (10) @(negedge clk);
    chk("R6 reset unaffected by aux", sys_rst_n, 1);
    vaux_ok = 1'b1;
    @(negedge clk);
    chk("R6 aux recovers", aux_fail_n, 1);

    // long hold
    long_dly = 1'b1;
    vmain_ok = 1'b0;
    repeat (4) @(negedge clk);
    vmain_ok = 1'b1;
    mark = tk_total;
    wait_release(mark, t);
    chk("R4 long hold ticks", t, LONG);
    long_dly = 1'b0;
    repeat (4) @(negedge clk);

    // short manual presses rejected
    minv = 1;
    man_rst_raw_n = 1'b0;
    repeat (20) begin @(negedge clk); if (sys_rst_n !== 1'b1) minv = 0; end
    man_rst_raw_n = 1'b1;
    repeat (40) begin @(negedge clk); if (sys_rst_n !== 1'b1) minv = 0; end
    chk("R7 ten-tick press ignored", minv, 1);
    man_rst_raw_n = 1'b0;
    repeat (28) begin @(negedge clk); if (sys_rst_n !== 1'b1) minv = 0; end
    man_rst_raw_n = 1'b1;
    repeat (2) begin @(negedge clk); if (sys_rst_n !== 1'b1) minv = 0; end
    man_rst_raw_n = 1'b0;
    repeat (28) begin @(negedge clk); if (sys_rst_n !== 1'b1) minv = 0; end
    man_rst_raw_n = 1'b1;
    repeat (40) begin @(negedge clk); if (sys_rst_n !== 1'b1) minv = 0; end
    chk("R7 bounce clears debounce count", minv, 1);

    // accepted manual press
    man_rst_raw_n = 1'b0;
    repeat (60) @(negedge clk);
    chk("R8 manual press holds reset", sys_rst_n, 0);
    chk("R10 busy during manual reset", busy, 1);
    man_rst_raw_n = 1'b1;
    mark = tk_total;
    wait_release(mark, t);
    chk("R8 release after debounce plus hold", (t >= SHORT + DEB && t <= SHORT + DEB + 2) ? 1 : 0, 1);

    // restart during hold
    vmain_ok = 1'b0;
    repeat (3) @(negedge clk);
    vmain_ok = 1'b1;
    mark0 = tk_total;
    repeat (200) @(negedge clk);
    chk("R9 still holding mid-count", sys_rst_n, 0);
    vmain_ok = 1'b0;
    repeat (3) @(negedge clk);
    vmain_ok = 1'b1;
    mark = tk_total;
    wait_release(mark, t);
    chk("R9 full hold after restart", t, SHORT);
    chk("R9 total exceeds single hold", (tk_total - mark0 > SHORT) ? 1 : 0, 1);

    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule